// File: doc/BRIEF.md
# Four-Channel Pulse Width Modulator

This block produces four independent pulse-width-modulated outputs and is set up through a small word-addressed register bus. Software writes one control word and one configuration word per channel, and every register reads back exactly as written. The control word holds an enable bit and a 2-bit step-size code for each channel. A configuration word packs the period length and the high time, both counted in steps.

Each channel divides the module clock down to a step rate of 1, 8, 64 or 512 clock cycles per step. The 512 setting is the two sub-dividers of 8 and 64 used in cascade. A step counter runs from 0 up to the period length, and the output stays high for the first duty steps of each period. New settings written while a channel runs are held back until the current period ends, so a change never produces a runt pulse.

Top module: `pwm_quad`

## Requirements
- R1: After reset every register reads 0 and all four outputs are low.
- R2: The control word is at address 0x00 and channel n's configuration word is at 0x04+4n. All 32 bits of each word read back as last written. Every other address reads 0, and writes to it change nothing.
- R3: Bit n of the control word enables channel n. The write is registered at a clock edge, and the period starts fresh with step 0 on the following edge.
- R4: A configuration word holds the period in bits 7:0 and the duty in bits 23:16. The output is high while the step count is below the duty and low for the rest of the period, which lasts period-length steps.
- R5: Channel n's step code is in control bits 4+2n+1:4+2n. Code 0 gives 1 clock per step, 1 gives 8, 2 gives 64, and 3 gives 512.
- R6: A duty of 0 holds the output low. A duty equal to or above the period length holds it high.
- R7: A period length of 0 holds the output low.
- R8: Clearing a channel's enable bit drives its output low from the next edge and clears its step and prescale counters. A later enable starts a fresh period.
- R9: Period, duty and step code written while a channel runs take effect only at the next period boundary.
- R10: The channels run independently, each with its own settings, at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Write strobe for the register bus |
| reg_addr | input | 5 | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, same cycle |
| pwm_out | output | 4 | One modulated output per channel |

## Verification
The bench rewrites the period, duty and step code four cycles into a running period and expects the old waveform to finish untouched. A design that applied the change at once would show a shortened pulse or a cut period. It drives the limit duties (0, equal to the period, and above it) and a zero period. A wrong compare there shows up as a stray one-step pulse, or as an output stuck high. It stops a channel mid-period and re-enables it. A design that kept its step counter would resume partway through the waveform and not at step 0. It runs all four step codes, including the cascaded 512 setting. A decoder using the wrong bit pair or the wrong ratio would produce steps of the wrong length.

// File: rtl/pwm_quad.sv
module pwm_quad #(
  parameter int NCH      = 4,
  parameter int DW       = 32,
  parameter int AW       = 5,
  parameter int CW       = 8,
  parameter int DUTY_LSB = 16,
  parameter int SUB_LOG  = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic [NCH-1:0] pwm_out
);
  localparam int PRE_W = SUB_LOG * 3;
  localparam int CODE_LSB = NCH;

  logic [DW-1:0]        ctrl_q;
  logic [NCH*DW-1:0]    cfg_v;
  logic [NCH-1:0]       run_v;
  logic [NCH*CW-1:0]    tb_v;
  logic [NCH*CW-1:0]    stp_v;
  logic [NCH*PRE_W-1:0] pre_v;
  logic [NCH*2-1:0]     div_v;

  always_ff @(posedge clk) begin
    if (!rst_n) ctrl_q <= '0;
    else if (reg_we && reg_addr == AW'(0)) ctrl_q <= reg_wdata;
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == AW'(0)) reg_rdata = ctrl_q;
    for (int i = 0; i < NCH; i++)
      if (reg_addr == AW'(4 + 4 * i)) reg_rdata = cfg_v[i*DW +: DW];
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic [DW-1:0]    cfg_r;
    logic             run_r;
    logic [CW-1:0]    tb_r, du_r, stp_r;
    logic [1:0]       div_r;
    logic [PRE_W-1:0] pre_r;
    logic             en, tick, last, reload;
    logic [PRE_W-1:0] lim;

    always_ff @(posedge clk) begin
      if (!rst_n) cfg_r <= '0;
      else if (reg_we && reg_addr == AW'(4 + 4 * ch)) cfg_r <= reg_wdata;
    end

    assign en     = ctrl_q[ch];
    assign lim    = (PRE_W'(1) << (SUB_LOG * div_r)) - PRE_W'(1);
    assign tick   = pre_r == lim;
    assign last   = stp_r == tb_r - CW'(1);
    assign reload = !run_r || tb_r == '0 || (tick && last);

    always_ff @(posedge clk) begin
      if (!rst_n || !en) begin
        run_r <= 1'b0;
        tb_r  <= '0;
        du_r  <= '0;
        div_r <= '0;
        pre_r <= '0;
        stp_r <= '0;
      end else if (reload) begin
        run_r <= 1'b1;
        tb_r  <= cfg_r[CW-1:0];
        du_r  <= cfg_r[DUTY_LSB +: CW];
        div_r <= ctrl_q[CODE_LSB + 2*ch +: 2];
        pre_r <= '0;
        stp_r <= '0;
      end else if (tick) begin
        pre_r <= '0;
        stp_r <= stp_r + CW'(1);
      end else begin
        pre_r <= pre_r + PRE_W'(1);
      end
    end

    assign pwm_out[ch] = run_r && tb_r != '0 && stp_r < du_r;

    assign cfg_v[ch*DW +: DW]       = cfg_r;
    assign run_v[ch]                = run_r;
    assign tb_v[ch*CW +: CW]        = tb_r;
    assign stp_v[ch*CW +: CW]       = stp_r;
    assign pre_v[ch*PRE_W +: PRE_W] = pre_r;
    assign div_v[ch*2 +: 2]         = div_r;
  end
endmodule

// File: rtl/pwm_quad_chk.sv
module pwm_quad_chk #(
  parameter int NCH     = 4,
  parameter int DW      = 32,
  parameter int AW      = 5,
  parameter int CW      = 8,
  parameter int SUB_LOG = 3
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     reg_we,
  input logic [AW-1:0]            reg_addr,
  input logic [DW-1:0]            reg_wdata,
  input logic [DW-1:0]            ctrl_q,
  input logic [NCH*DW-1:0]        cfg_v,
  input logic [NCH-1:0]           pwm_out,
  input logic [NCH-1:0]           run_v,
  input logic [NCH*CW-1:0]        tb_v,
  input logic [NCH*CW-1:0]        stp_v,
  input logic [NCH*SUB_LOG*3-1:0] pre_v,
  input logic [NCH*2-1:0]         div_v
);
  localparam int PRE_W = SUB_LOG * 3;

  p_ctrl_readback_r2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we && reg_addr == AW'(0) |=> ctrl_q == $past(reg_wdata));

  for (genvar i = 0; i < NCH; i++) begin : g_chk
    p_cfg_readback_r2: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we && reg_addr == AW'(4 + 4 * i) |=> cfg_v[i*DW +: DW] == $past(reg_wdata));

    p_off_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_q[i] |=> !pwm_out[i] && stp_v[i*CW +: CW] == '0 && pre_v[i*PRE_W +: PRE_W] == '0);

    p_step_in_period_r4: assert property (@(posedge clk) disable iff (!rst_n)
      run_v[i] && tb_v[i*CW +: CW] != '0 |-> stp_v[i*CW +: CW] < tb_v[i*CW +: CW]);

    p_pre_in_ratio_r5: assert property (@(posedge clk) disable iff (!rst_n)
      {1'b0, pre_v[i*PRE_W +: PRE_W]} <
        ((PRE_W+1)'(1) << (SUB_LOG * div_v[i*2 +: 2])));

    p_update_at_boundary_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !($stable(tb_v[i*CW +: CW]) && $stable(div_v[i*2 +: 2])) |->
        stp_v[i*CW +: CW] == '0 && pre_v[i*PRE_W +: PRE_W] == '0);
  end
endmodule

bind pwm_quad pwm_quad_chk #(.NCH(NCH), .DW(DW), .AW(AW), .CW(CW), .SUB_LOG(SUB_LOG)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .ctrl_q(ctrl_q), .cfg_v(cfg_v), .pwm_out(pwm_out), .run_v(run_v), .tb_v(tb_v),
  .stp_v(stp_v), .pre_v(pre_v), .div_v(div_v)
);

// File: tb/pwm_quad_bench.sv
module pwm_quad_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [3:0]  pwm_out;

  int ntests = 0;
  int nfail = 0;

  typedef struct { logic [3:0] v; string tag; } exp_t;
  exp_t q[$];

  int m_en[4], tb0[4], d0[4], r0[4], tb1[4], d1[4], r1[4], sw[4];

  pwm_quad u_pwm_quad (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pwm_out(pwm_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [31:0] got, input logic [31:0] exp);
    ntests++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic bit wave(input int tb, input int d, input int r, input int j);
    int s;
    if (tb == 0) return 1'b0;
    s = (j / r) % tb;
    return s < d;
  endfunction

  function automatic logic [3:0] exp_at(input int j);
    logic [3:0] v;
    for (int c = 0; c < 4; c++) begin
      if (m_en[c] == 0) v[c] = 1'b0;
      else if (j < sw[c]) v[c] = wave(tb0[c], d0[c], r0[c], j);
      else v[c] = wave(tb1[c], d1[c], r1[c], j - sw[c]);
    end
    return v;
  endfunction

  task automatic clear_model();
    for (int c = 0; c < 4; c++) begin
      m_en[c] = 0; tb0[c] = 0; d0[c] = 0; r0[c] = 1;
      tb1[c] = 0; d1[c] = 0; r1[c] = 1; sw[c] = 1 << 30;
    end
  endtask

  task automatic set_model(input int c, input int tb, input int d, input int code);
    m_en[c] = 1; tb0[c] = tb; d0[c] = d; r0[c] = 1 << (3 * code);
    tb1[c] = tb; d1[c] = d; r1[c] = r0[c]; sw[c] = 1 << 30;
  endtask

  task automatic push_win(input string tag, input int n);
    exp_t e;
    for (int j = 0; j < n; j++) begin
      e.v = exp_at(j);
      e.tag = tag;
      q.push_back(e);
    end
  endtask

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
  endtask

  task automatic reg_write(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_read_check(input logic [4:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    reg_addr = a;
    #1;
    check(reg_rdata == exp, tag, reg_rdata, exp);
  endtask

  function automatic logic [31:0] cfg_word(input int tb, input int d);
    return (32'(d) << 16) | 32'(tb);
  endfunction

  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        e = q.pop_front();
        check(pwm_out === e.v, e.tag, 32'(pwm_out), 32'(e.v));
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    nfail++;
    ntests++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end

  initial begin
    clear_model();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 5; a++) reg_read_check(5'(4 * a), 32'h0, "R1 reset register");
    check(pwm_out == 4'h0, "R1 reset outputs", 32'(pwm_out), 32'h0);

    // R2 readback of every bit and unmapped addresses
    for (int c = 0; c < 4; c++) reg_write(5'(4 + 4 * c), 32'hC3A5_5A3C ^ (32'h1111_1111 * 32'(c)));
    reg_write(5'h00, 32'hA5A5_FF00);
    reg_read_check(5'h00, 32'hA5A5_FF00, "R2 control readback");
    for (int c = 0; c < 4; c++)
      reg_read_check(5'(4 + 4 * c), 32'hC3A5_5A3C ^ (32'h1111_1111 * 32'(c)), "R2 config readback");
    reg_write(5'h14, 32'hFFFF_FFFF);
    reg_write(5'h02, 32'hFFFF_FFFF);
    reg_read_check(5'h14, 32'h0, "R2 unmapped read");
    reg_read_check(5'h02, 32'h0, "R2 unaligned read");
    reg_read_check(5'h00, 32'hA5A5_FF00, "R2 control untouched by unmapped write");
    reg_read_check(5'h04, 32'hC3A5_5A3C, "R2 config untouched by unmapped write");
    reg_write(5'h00, 32'h0);

    // R3 R4 basic waveform on channel 0
    reg_write(5'h04, cfg_word(10, 3));
    reg_write(5'h00, 32'h1);
    clear_model(); set_model(0, 10, 3, 0);
    push_win("R3 R4 channel 0 waveform", 25);
    drain();

    // R8 disable then fresh restart
    reg_write(5'h00, 32'h0);
    clear_model();
    push_win("R8 disabled output low", 12);
    drain();
    reg_write(5'h00, 32'h1);
    clear_model(); set_model(0, 10, 3, 0);
    push_win("R8 re-enable fresh period", 22);
    drain();
    reg_write(5'h00, 32'h0);

    // R5 step codes 1..3 on channels 1..3
    for (int c = 1; c < 4; c++) begin
      int tb, d, n;
      tb = (c == 1) ? 4 : (c == 2) ? 3 : 2;
      d  = (c == 1) ? 1 : (c == 2) ? 2 : 1;
      n  = 2 * tb * (1 << (3 * c)) + 5;
      reg_write(5'(4 + 4 * c), cfg_word(tb, d));
      reg_write(5'h00, (32'h1 << c) | (32'(c) << (4 + 2 * c)));
      clear_model(); set_model(c, tb, d, c);
      push_win($sformatf("R5 step code %0d channel %0d", c, c), n);
      drain();
      reg_write(5'h00, 32'h0);
    end

    // R6 R7 limit duties and zero period, all at once
    reg_write(5'h04, cfg_word(0, 3));
    reg_write(5'h08, cfg_word(5, 0));
    reg_write(5'h0C, cfg_word(5, 5));
    reg_write(5'h10, cfg_word(5, 9));
    reg_write(5'h00, 32'hF);
    clear_model();
    set_model(0, 0, 3, 0); set_model(1, 5, 0, 0); set_model(2, 5, 5, 0); set_model(3, 5, 9, 0);
    push_win("R6 R7 limit duty and zero period", 20);
    drain();
    reg_write(5'h00, 32'h0);

    // R10 independent channels with mixed settings
    reg_write(5'h04, cfg_word(7, 2));
    reg_write(5'h08, cfg_word(3, 2));
    reg_write(5'h0C, cfg_word(4, 1));
    reg_write(5'h10, cfg_word(5, 4));
    reg_write(5'h00, 32'hF | (32'h1 << 6) | (32'h1 << 10));
    clear_model();
    set_model(0, 7, 2, 0); set_model(1, 3, 2, 1); set_model(2, 4, 1, 0); set_model(3, 5, 4, 1);
    push_win("R10 four channels together", 150);
    drain();
    reg_write(5'h00, 32'h0);

    // R9 mid-period rewrite of period, duty and step code
    reg_write(5'h04, cfg_word(10, 3));
    reg_write(5'h00, 32'h1);
    clear_model(); set_model(0, 10, 3, 0);
    tb1[0] = 5; d1[0] = 2; r1[0] = 8; sw[0] = 10;
    push_win("R9 update held to period boundary", 93);
    repeat (4) @(negedge clk);
    reg_write(5'h04, cfg_word(5, 2));
    reg_write(5'h00, 32'h11);
    drain();
    reg_write(5'h00, 32'h0);

    $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end
endmodule